// File: doc/BRIEF.md
# Dispatch Group Slot Accountant

This block follows an in-order instruction stream as it is packed into fixed-size dispatch groups. Each cycle it may receive one instruction descriptor. The descriptor holds a pre-decoded issue-class code, branch, record-form and load flags, the instruction's own tag, and up to `NUM_PRED` predecessor tags. Each predecessor tag is marked either as a memory-ordering edge from a store or as a data edge. From these inputs the block keeps a running slot count and branch count for the open group. It closes the group when a packing rule requires it, and it records which tags belong to the group.

Before the instruction is committed, the block reports a same-group hazard in the same cycle. There are two such hazards: a load ordered behind a store of the open group, and a branch fed by a special-register write of the open group. It also reports how many no-ops the scheduler should insert. A separate no-op event input accounts for each no-op that is actually inserted. A mode input selects whether the target has a group-terminating no-op.

Top module: `dispatch_group_acct`

## Requirements
- R1: Slot cost by class code. Codes 1 (divide), 2 (update load), 3 (update store) and 4 (algebraic load) cost 2. Codes 5 (indexed update), 6 (reserve load), 7 (conditional store) and 8 (move into condition register) cost 4. Every other code, including 9 (condition logical), 10 (condition read), 11 (special-register write) and 12 to 15, costs 1.
- R2: An instruction with the record-form flag set whose class cost is 1 is charged 2 slots.
- R3: An instruction costing more than 1 slot, or of class 9, 10 or 11, must open a group. If the slot count is nonzero when it is accepted, the count, the branch count and the membership are cleared before it is added.
- R4: An instruction accepted while the slot count equals 5, or a branch accepted while the branch count is 1, clears the group and is not counted or recorded in it.
- R5: Each branch added to a group increments the branch count, which never exceeds 1.
- R6: `hazard` is high in the same cycle when a valid load carries a store-edge predecessor (`pred_is_data`=0) whose tag matches a real instruction entry of the open group.
- R7: `hazard` is high in the same cycle when a valid branch carries a data-edge predecessor (`pred_is_data`=1) whose tag matches a class-11 entry of the open group.
- R8: `pad_count` is 0 without a hazard or when the slot count is 6 or more. Otherwise it is 1 when `term_noop_mode` is high and 5 minus the slot count when it is low.
- R9: A no-op event clears the group when `term_noop_mode` is high or the slot count equals 6. Otherwise it increments the slot count and adds an untagged filler entry that no predecessor can match.
- R10: A no-op event takes precedence over an instruction in the same cycle, and that instruction is ignored. With neither input valid, the counts and membership do not change.
- R11: Synchronous active-high reset clears the slot count, the branch count and all membership entries.
- R12: Membership holds at most 6 entries, and later entries of the same group are not recorded. The slot count saturates at 15 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| term_noop_mode | input | 1 | Target has a group-terminating no-op |
| nop_event | input | 1 | One no-op is being inserted this cycle |
| ins_valid | input | 1 | Instruction descriptor valid |
| ins_class | input | 4 | Issue-class code |
| ins_branch | input | 1 | Instruction is a branch |
| ins_record | input | 1 | Instruction is the record form |
| ins_load | input | 1 | Instruction may load |
| ins_tag | input | TAG_W | Tag of this instruction |
| pred_valid | input | NUM_PRED | Predecessor slot valid |
| pred_tag | input | NUM_PRED*TAG_W | Predecessor tags, slot 0 in the low bits |
| pred_is_data | input | NUM_PRED | 1: data edge, 0: store memory-ordering edge |
| hazard | output | 1 | Same-group hazard for the presented instruction |
| pad_count | output | 3 | No-ops requested before the instruction |
| slot_count | output | SLOT_W | Slots used in the open group |
| branch_count | output | 2 | Branches in the open group |

## Verification
A wrong slot or branch count appears on `slot_count` or `branch_count` one cycle after the instruction that caused it. It also skews `pad_count` the next time a hazard is presented. A corrupted membership entry shows only when a later instruction names that tag as a predecessor. The bench therefore reuses a small tag space so that stale, missing and filler entries are probed within a few cycles of being written. Group-closing slips, such as one extra or one missing clear, show at the next slot-count edge as a value that is off by the cost of the instruction.

// File: rtl/dg_pkg.sv
package dg_pkg;

    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        IC_PLAIN      = 4'd0,
        IC_DIVIDE     = 4'd1,
        IC_LOAD_UPD   = 4'd2,
        IC_STORE_UPD  = 4'd3,
        IC_LOAD_ALG   = 4'd4,
        IC_IDX_UPD    = 4'd5,
        IC_RESV_LOAD  = 4'd6,
        IC_COND_STORE = 4'd7,
        IC_CR_MOVE_IN = 4'd8,
        IC_CR_LOGIC   = 4'd9,
        IC_CR_READ    = 4'd10,
        IC_SPR_WRITE  = 4'd11
    } issue_class_e;

    typedef struct packed {
        logic [2:0] cost;
        logic       opens_group;
        logic       spr_write;
    } class_info_t;

    function automatic class_info_t decode_class(logic [CLS_W-1:0] cls, logic record);
        class_info_t info;
        info.cost = 3'd1;
        case (cls)
            IC_DIVIDE, IC_LOAD_UPD, IC_STORE_UPD, IC_LOAD_ALG:          info.cost = 3'd2;
            IC_IDX_UPD, IC_RESV_LOAD, IC_COND_STORE, IC_CR_MOVE_IN:     info.cost = 3'd4;
            default:                                                    info.cost = 3'd1;
        endcase
        if (info.cost == 3'd1 && record)
            info.cost = 3'd2;
        info.opens_group = (info.cost > 3'd1) ||
                           (cls == IC_CR_LOGIC) || (cls == IC_CR_READ) || (cls == IC_SPR_WRITE);
        info.spr_write = (cls == IC_SPR_WRITE);
        return info;
    endfunction

endpackage

// File: rtl/dg_class_decode.sv
module dg_class_decode
    import dg_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    input  logic             record,
    output class_info_t      info
);
    always_comb info = decode_class(cls, record);
endmodule

// File: rtl/dg_group_members.sv
module dg_group_members #(
    parameter int DEPTH    = 6,
    parameter int TAG_W    = 6,
    parameter int NUM_PRED = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      push,
    input  logic                      push_filler,
    input  logic                      push_spr,
    input  logic [TAG_W-1:0]          push_tag,
    input  logic [NUM_PRED-1:0]       pred_valid,
    input  logic [NUM_PRED*TAG_W-1:0] pred_tag,
    input  logic [NUM_PRED-1:0]       pred_is_data,
    output logic                      hit_store,
    output logic                      hit_spr
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] ent_valid;
    logic [DEPTH-1:0] ent_filler;
    logic [DEPTH-1:0] ent_spr;
    logic [TAG_W-1:0] ent_tag [DEPTH];
    logic [CNT_W-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst)
            fill_q <= '0;
        else if (clear)
            fill_q <= push ? CNT_W'(1) : '0;
        else if (push && fill_q < CNT_W'(DEPTH))
            fill_q <= fill_q + CNT_W'(1);
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic wr;
        assign wr = push && (clear ? (e == 0) : (fill_q == CNT_W'(e)));
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[e]  <= 1'b0;
                ent_filler[e] <= 1'b0;
                ent_spr[e]    <= 1'b0;
                ent_tag[e]    <= '0;
            end else if (wr) begin
                ent_valid[e]  <= 1'b1;
                ent_filler[e] <= push_filler;
                ent_spr[e]    <= push_spr && !push_filler;
                ent_tag[e]    <= push_tag;
            end else if (clear) begin
                ent_valid[e]  <= 1'b0;
            end
        end
    end

    logic [NUM_PRED-1:0] real_hit;
    logic [NUM_PRED-1:0] spr_hit;

    for (genvar p = 0; p < NUM_PRED; p++) begin : g_pred
        logic [TAG_W-1:0] ptag;
        logic [DEPTH-1:0] m;
        assign ptag = pred_tag[p*TAG_W +: TAG_W];
        for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
            assign m[e] = ent_valid[e] && !ent_filler[e] && (ent_tag[e] == ptag);
        end
        assign real_hit[p] = |m;
        assign spr_hit[p]  = |(m & ent_spr);
    end

    assign hit_store = |(pred_valid & ~pred_is_data & real_hit);
    assign hit_spr   = |(pred_valid & pred_is_data & spr_hit);
endmodule

// File: rtl/dg_pad_calc.sv
module dg_pad_calc #(
    parameter int SLOT_W = 4
) (
    input  logic              hazard,
    input  logic              term_mode,
    input  logic [SLOT_W-1:0] slots,
    output logic [2:0]        pad
);
    always_comb begin
        if (!hazard || slots >= SLOT_W'(6))
            pad = 3'd0;
        else if (term_mode)
            pad = 3'd1;
        else
            pad = 3'(5 - int'(slots));
    end
endmodule

// File: rtl/dispatch_group_acct.sv
module dispatch_group_acct
    import dg_pkg::*;
#(
    parameter int TAG_W    = 6,
    parameter int NUM_PRED = 3,
    parameter int DEPTH    = 6,
    parameter int SLOT_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      term_noop_mode,
    input  logic                      nop_event,
    input  logic                      ins_valid,
    input  logic [CLS_W-1:0]          ins_class,
    input  logic                      ins_branch,
    input  logic                      ins_record,
    input  logic                      ins_load,
    input  logic [TAG_W-1:0]          ins_tag,
    input  logic [NUM_PRED-1:0]       pred_valid,
    input  logic [NUM_PRED*TAG_W-1:0] pred_tag,
    input  logic [NUM_PRED-1:0]       pred_is_data,
    output logic                      hazard,
    output logic [2:0]                pad_count,
    output logic [SLOT_W-1:0]         slot_count,
    output logic [1:0]                branch_count
);
    localparam int SLOT_MAX = (1 << SLOT_W) - 1;

    logic [SLOT_W-1:0] slots_q, slots_d;
    logic [1:0]        br_q, br_d;
    class_info_t       info;
    logic              hit_store, hit_spr;
    logic              clr, push, push_filler;

    function automatic logic [SLOT_W-1:0] sat_add(logic [SLOT_W-1:0] a, logic [2:0] b);
        logic [SLOT_W:0] s;
        s = {1'b0, a} + (SLOT_W+1)'(b);
        return (s > (SLOT_W+1)'(SLOT_MAX)) ? SLOT_W'(SLOT_MAX) : s[SLOT_W-1:0];
    endfunction

    dg_class_decode u_decode (
        .cls    (ins_class),
        .record (ins_record),
        .info   (info)
    );

    dg_group_members #(
        .DEPTH    (DEPTH),
        .TAG_W    (TAG_W),
        .NUM_PRED (NUM_PRED)
    ) u_members (
        .clk          (clk),
        .rst          (rst),
        .clear        (clr),
        .push         (push),
        .push_filler  (push_filler),
        .push_spr     (info.spr_write),
        .push_tag     (ins_tag),
        .pred_valid   (pred_valid),
        .pred_tag     (pred_tag),
        .pred_is_data (pred_is_data),
        .hit_store    (hit_store),
        .hit_spr      (hit_spr)
    );

    assign hazard = ins_valid && ((ins_load && hit_store) || (ins_branch && hit_spr));

    dg_pad_calc #(.SLOT_W(SLOT_W)) u_pad (
        .hazard    (hazard),
        .term_mode (term_noop_mode),
        .slots     (slots_q),
        .pad       (pad_count)
    );

    always_comb begin
        logic reopen;
        clr         = 1'b0;
        push        = 1'b0;
        push_filler = 1'b0;
        slots_d     = slots_q;
        br_d        = br_q;
        reopen      = 1'b0;
        if (nop_event) begin
            if (term_noop_mode || slots_q == SLOT_W'(6)) begin
                clr     = 1'b1;
                slots_d = '0;
                br_d    = '0;
            end else begin
                push        = 1'b1;
                push_filler = 1'b1;
                slots_d     = sat_add(slots_q, 3'd1);
            end
        end else if (ins_valid) begin
            if (slots_q == SLOT_W'(5) || (ins_branch && br_q == 2'd1)) begin
                clr     = 1'b1;
                slots_d = '0;
                br_d    = '0;
            end else begin
                reopen  = info.opens_group && (slots_q != '0);
                clr     = reopen;
                push    = 1'b1;
                slots_d = sat_add(reopen ? '0 : slots_q, info.cost);
                br_d    = (reopen ? 2'd0 : br_q) + {1'b0, ins_branch};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            br_q    <= '0;
        end else begin
            slots_q <= slots_d;
            br_q    <= br_d;
        end
    end

    assign slot_count   = slots_q;
    assign branch_count = br_q;
endmodule

// File: rtl/dg_acct_checks.sv
module dg_acct_checks
    import dg_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              term_noop_mode,
    input logic              nop_event,
    input logic              ins_valid,
    input logic [CLS_W-1:0]  ins_class,
    input logic              ins_branch,
    input logic              ins_record,
    input logic              ins_load,
    input logic              hazard,
    input logic [2:0]        pad_count,
    input logic [SLOT_W-1:0] slot_count,
    input logic [1:0]        branch_count
);
    localparam int SMAX = (1 << SLOT_W) - 1;

    p_pad_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !hazard |-> pad_count == 3'd0);

    p_pad_term_r8: assert property (@(posedge clk) disable iff (rst)
        (hazard && term_noop_mode && slot_count < SLOT_W'(6)) |-> pad_count == 3'd1);

    p_haz_src_r6: assert property (@(posedge clk) disable iff (rst)
        hazard |-> (ins_valid && (ins_load || ins_branch)));

    p_one_branch_r5: assert property (@(posedge clk) disable iff (rst)
        branch_count <= 2'd1);

    p_full_close_r4: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !nop_event && slot_count == SLOT_W'(5))
        |=> (slot_count == '0 && branch_count == '0));

    p_noop_inc_r9: assert property (@(posedge clk) disable iff (rst)
        (nop_event && !term_noop_mode && slot_count != SLOT_W'(6) && slot_count != SLOT_W'(SMAX))
        |=> slot_count == $past(slot_count) + SLOT_W'(1));

    p_noop_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (nop_event && term_noop_mode) |=> (slot_count == '0 && branch_count == '0));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!ins_valid && !nop_event) |=> ($stable(slot_count) && $stable(branch_count)));

    p_cr_first_r3: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !nop_event && slot_count != SLOT_W'(5) && ins_class == IC_CR_LOGIC &&
         !(ins_branch && branch_count == 2'd1))
        |=> slot_count == ($past(ins_record) ? SLOT_W'(2) : SLOT_W'(1)));
endmodule

bind dispatch_group_acct dg_acct_checks #(.SLOT_W(SLOT_W)) u_checks (
    .clk            (clk),
    .rst            (rst),
    .term_noop_mode (term_noop_mode),
    .nop_event      (nop_event),
    .ins_valid      (ins_valid),
    .ins_class      (ins_class),
    .ins_branch     (ins_branch),
    .ins_record     (ins_record),
    .ins_load       (ins_load),
    .hazard         (hazard),
    .pad_count      (pad_count),
    .slot_count     (slot_count),
    .branch_count   (branch_count)
);

// File: tb/test_dispatch_group_acct.sv
module test_dispatch_group_acct;
    localparam int TAG_W = 6;
    localparam int NP    = 3;
    localparam int DEPTH = 6;
    localparam int SLOTW = 4;
    localparam int SMAX  = 15;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst, term_noop_mode, nop_event, ins_valid, ins_branch, ins_record, ins_load;
    logic [3:0]       ins_class;
    logic [TAG_W-1:0] ins_tag;
    logic [NP-1:0]    pred_valid, pred_is_data;
    logic [NP*TAG_W-1:0] pred_tag;
    logic             hazard;
    logic [2:0]       pad_count;
    logic [SLOTW-1:0] slot_count;
    logic [1:0]       branch_count;

    dispatch_group_acct #(.TAG_W(TAG_W), .NUM_PRED(NP), .DEPTH(DEPTH), .SLOT_W(SLOTW)) i_dispatch_group_acct (
        .clk(clk), .rst(rst), .term_noop_mode(term_noop_mode), .nop_event(nop_event),
        .ins_valid(ins_valid), .ins_class(ins_class), .ins_branch(ins_branch),
        .ins_record(ins_record), .ins_load(ins_load), .ins_tag(ins_tag),
        .pred_valid(pred_valid), .pred_tag(pred_tag), .pred_is_data(pred_is_data),
        .hazard(hazard), .pad_count(pad_count), .slot_count(slot_count), .branch_count(branch_count)
    );

    typedef struct { int tag; bit filler; bit spr; } ent_t;
    ent_t grp[$];
    int   m_slots, m_br;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    function automatic int cost_of(int c, bit rec);
        int k = (c >= 1 && c <= 4) ? 2 : (c >= 5 && c <= 8) ? 4 : 1;
        if (k == 1 && rec) k = 2;
        return k;
    endfunction

    function automatic bit m_hazard();
        bit h = 0;
        if (!ins_valid) return 0;
        for (int p = 0; p < NP; p++) begin
            if (!pred_valid[p]) continue;
            foreach (grp[i]) begin
                if (grp[i].filler || grp[i].tag != int'(pred_tag[p*TAG_W +: TAG_W])) continue;
                if (!pred_is_data[p] && ins_load) h = 1;
                if (pred_is_data[p] && ins_branch && grp[i].spr) h = 1;
            end
        end
        return h;
    endfunction

    task automatic chk(string lbl, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", lbl, what, act, exp, $time);
        end
    endtask

    task automatic m_clear();
        grp.delete(); m_slots = 0; m_br = 0;
    endtask

    task automatic m_push(int tag, bit filler, bit spr);
        ent_t e;
        e.tag = tag; e.filler = filler; e.spr = spr;
        if (grp.size() < DEPTH) grp.push_back(e);
    endtask

    task automatic cyc(string lbl);
        bit h; int pad;
        #1;
        if (!rst) begin
            h   = m_hazard();
            pad = (!h || m_slots >= 6) ? 0 : (term_noop_mode ? 1 : 5 - m_slots);
            chk(lbl, "slot_count", int'(slot_count), m_slots);
            chk(lbl, "branch_count", int'(branch_count), m_br);
            chk(lbl, "hazard", int'(hazard), int'(h));
            chk(lbl, "pad_count", int'(pad_count), pad);
        end
        if (rst) m_clear();
        else if (nop_event) begin
            if (term_noop_mode || m_slots == 6) m_clear();
            else begin m_slots = (m_slots + 1 > SMAX) ? SMAX : m_slots + 1; m_push(0, 1, 0); end
        end else if (ins_valid) begin
            int c = int'(ins_class);
            if (m_slots == 5 || (ins_branch && m_br == 1)) m_clear();
            else begin
                int k = cost_of(c, ins_record);
                bit first = (k > 1) || c == 9 || c == 10 || c == 11;
                if (first && m_slots != 0) m_clear();
                m_slots = (m_slots + k > SMAX) ? SMAX : m_slots + k;
                m_br += int'(ins_branch);
                m_push(int'(ins_tag), 0, c == 11);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        ins_valid = 0; nop_event = 0; pred_valid = '0; pred_is_data = '0; pred_tag = '0;
        ins_branch = 0; ins_record = 0; ins_load = 0; ins_class = 0; ins_tag = 0;
    endtask

    task automatic ins(int c, bit b, bit rec, bit ld, int tg);
        idle();
        ins_valid = 1; ins_class = 4'(c); ins_branch = b; ins_record = rec; ins_load = ld; ins_tag = TAG_W'(tg);
    endtask

    task automatic pred(int p, int tg, bit data);
        pred_valid[p] = 1; pred_is_data[p] = data; pred_tag[p*TAG_W +: TAG_W] = TAG_W'(tg);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(); term_noop_mode = 0; rst = 1; m_clear();
        @(negedge clk); @(negedge clk);
        rst = 0;
        idle(); cyc("R11");                                  // reset state
        // R1: class costs
        ins(0, 0, 0, 0, 1); cyc("R1");
        ins(0, 0, 0, 0, 2); cyc("R1");
        ins(1, 0, 0, 0, 3); cyc("R1");                       // divide reopens
        ins(0, 0, 0, 0, 4); cyc("R1");
        ins(6, 0, 0, 0, 5); cyc("R1");                       // cost 4 reopens
        ins(13, 0, 0, 0, 6); cyc("R1");
        idle(); cyc("R1");
        // R2 record form
        rst = 1; cyc("R11"); rst = 0;
        ins(0, 0, 1, 0, 7); cyc("R2");
        ins(12, 0, 1, 0, 8); cyc("R2");
        idle(); cyc("R2");
        // R3 condition logical mid group
        rst = 1; cyc("R11"); rst = 0;
        ins(0, 0, 0, 0, 1); cyc("R3");
        ins(9, 0, 0, 0, 2); cyc("R3");
        ins(10, 0, 1, 0, 3); cyc("R3");
        idle(); cyc("R3");
        // R4 / R5 close rules
        rst = 1; cyc("R11"); rst = 0;
        for (int i = 0; i < 5; i++) begin ins(0, 0, 0, 0, i); cyc("R4"); end
        ins(0, 0, 0, 0, 9); cyc("R4");
        ins(0, 1, 0, 0, 10); cyc("R5");
        ins(0, 1, 0, 0, 11); cyc("R5");
        ins(0, 1, 0, 0, 12); cyc("R5");
        idle(); cyc("R4");
        // R6 load after store, both pad modes (R8)
        rst = 1; cyc("R11"); rst = 0;
        ins(0, 0, 0, 0, 20); cyc("R6");
        ins(0, 0, 0, 0, 21); cyc("R6");
        ins(0, 0, 0, 1, 22); pred(1, 21, 0); cyc("R8");
        ins(0, 0, 0, 1, 22); pred(1, 21, 1); cyc("R6");      // data edge: no load hazard
        term_noop_mode = 1;
        ins(0, 0, 0, 1, 22); pred(2, 20, 0); cyc("R8");
        term_noop_mode = 0;
        // R7 branch after special-register write
        rst = 1; cyc("R11"); rst = 0;
        ins(11, 0, 0, 0, 30); cyc("R7");
        ins(0, 1, 0, 0, 31); pred(0, 30, 1); cyc("R7");
        ins(0, 1, 0, 0, 31); pred(0, 30, 0); cyc("R7");
        // R9 no-ops: filler is not matchable
        nop_event = 0; idle(); nop_event = 1; cyc("R9");
        ins(0, 0, 0, 1, 40); pred(0, 0, 0); cyc("R9");
        idle(); term_noop_mode = 1; nop_event = 1; cyc("R9");
        term_noop_mode = 0; idle(); cyc("R9");
        // R10 precedence and idle
        ins(0, 0, 0, 0, 41); nop_event = 1; cyc("R10");
        ins(0, 0, 0, 1, 42); pred(0, 41, 0); cyc("R10");     // 41 was ignored
        idle(); cyc("R10");
        // R12 capacity and saturation
        rst = 1; cyc("R11"); rst = 0;
        for (int i = 0; i < 5; i++) begin ins(0, 0, 0, 0, 50 + i); cyc("R12"); end
        idle(); nop_event = 1; cyc("R12");
        for (int i = 0; i < 12; i++) begin ins(0, 0, 0, 0, 60 + i); cyc("R12"); end
        ins(0, 0, 0, 1, 1); pred(0, 60, 0); cyc("R12");
        ins(0, 0, 0, 1, 1); pred(0, 52, 0); cyc("R12");
        idle(); nop_event = 1; cyc("R12");
        // mixed random traffic over a small tag space
        for (int n = 0; n < 4000; n++) begin
            idle();
            rst = ($urandom_range(0, 199) == 0);
            term_noop_mode = ($urandom_range(0, 3) == 0);
            nop_event = ($urandom_range(0, 7) == 0);
            ins_valid = ($urandom_range(0, 5) != 0);
            ins_class = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 0) ins_class = 0;
            ins_branch = ($urandom_range(0, 4) == 0);
            ins_record = ($urandom_range(0, 5) == 0);
            ins_load = ($urandom_range(0, 2) == 0);
            ins_tag = TAG_W'($urandom_range(0, 7));
            for (int p = 0; p < NP; p++)
                if ($urandom_range(0, 1) == 1) pred(p, $urandom_range(0, 7), $urandom_range(0, 1) == 1);
            cyc("R1");
            rst = 0;
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule